// File: doc/BRIEF.md
# GPIO Port Interrupt Cause Aggregator

This block turns the polarity-corrected input vector of a 32-line GPIO port into grouped interrupt requests for two processors. Each line has two possible interrupt sources:

- **Level source.** The line's input bit, used as it is and never stored.
- **Edge source.** A sticky bit in an edge-cause register. The bit is set when the corrected input goes from 0 to 1.

Each processor has its own level-enable mask and its own edge-enable mask. The masked per-line causes are ORed in groups of eight lines, which gives four request wires per processor.

Software reaches the five registers over a simple 32-bit bus. Writes take effect on the clock edge. Reads are combinational from the address. To acknowledge edge causes, software writes the cause register: every bit written as 0 is cleared, and every bit written as 1 is left as it was. This lets a handler clear exactly the lines it has serviced without a read-modify-write.

The bus decoder maps the address onto an enumerated register selector, and every register field is steered from that selector. The selector has these values:

| Selector | Offset |
|---|---|
| SEL_NONE | any other offset |
| SEL_CAUSE | 0x14 |
| SEL_EMASK0 | 0x18 |
| SEL_LMASK0 | 0x1C |
| SEL_EMASK1 | 0x30 |
| SEL_LMASK1 | 0x34 |

The block has no sequencing state. Its only transitions are the three possible updates of each cause bit on a clock edge: set, cleared, or held.

Top module: `gpio_irq_agg`

## Requirements
- R1: The registers sit at fixed byte offsets: edge cause 0x14, CPU0 edge mask 0x18, CPU0 level mask 0x1C, CPU1 edge mask 0x30, CPU1 level mask 0x34. Each mask reads back what was written. Any other offset reads 0, and a write to it changes no register.
- R2: A 0-to-1 change of input bit i between two clock edges sets cause bit i at the second edge. A 1-to-0 change sets nothing. A set bit stays set after the line returns low.
- R3: A write to offset 0x14 clears each cause bit whose write-data bit is 0 and leaves each bit whose write-data bit is 1 unchanged.
- R4: When a rising input and a clearing write hit the same cause bit in the same cycle, the bit ends up set.
- R5: The level cause of line i is input bit i AND its level-mask bit. It follows the input in the same cycle and is never latched.
- R6: The masked cause of line i for a CPU is (input AND that CPU's level mask) OR (edge cause AND that CPU's edge mask).
- R7: Request bit g of a CPU is the OR of the masked causes of lines 8g to 8g+7, for g = 0 to 3.
- R8: The masks of CPU0 and CPU1 are independent. A line enabled for one CPU only raises only that CPU's request.
- R9: Reset clears all four masks and the cause register, so both request vectors are 0. A line that is high while reset is released does not count as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| data_in | input | 32 | Polarity-corrected line values |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_cpu0 | output | 4 | Grouped requests for CPU0, one bit per eight lines |
| irq_cpu1 | output | 4 | Grouped requests for CPU1, one bit per eight lines |

## Verification
A wrong cause bit appears on the bus at offset 0x14 in the cycle right after the edge that stored it. It appears on a request wire in that same cycle once the matching edge mask is set.

A stale previous-input copy shows up as a missing or spurious cause bit, one cycle after the input changes or right after reset is released. Mask corruption shows up at once as a request raised on the wrong CPU or in the wrong group, or as a readback mismatch.

The same-cycle race between a rising edge and a clearing write is exercised directly, because an error there shows only as a single lost bit.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_CAUSE  = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_EMASK0 = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_LMASK0 = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_EMASK1 = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_LMASK1 = 8'h34;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CAUSE,
        SEL_EMASK0,
        SEL_LMASK0,
        SEL_EMASK1,
        SEL_LMASK1
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] addr);
        reg_sel_e sel;
        unique case (addr)
            OFS_CAUSE:  sel = SEL_CAUSE;
            OFS_EMASK0: sel = SEL_EMASK0;
            OFS_LMASK0: sel = SEL_LMASK0;
            OFS_EMASK1: sel = SEL_EMASK1;
            OFS_LMASK1: sel = SEL_LMASK1;
            default:    sel = SEL_NONE;
        endcase
        return sel;
    endfunction

    function automatic reg_sel_e edge_sel(input int cpu);
        return (cpu == 0) ? SEL_EMASK0 : SEL_EMASK1;
    endfunction

    function automatic reg_sel_e level_sel(input int cpu);
        return (cpu == 0) ? SEL_LMASK0 : SEL_LMASK1;
    endfunction

endpackage

// File: rtl/gpio_edge_cause.sv
module gpio_edge_cause #(
    parameter int LINES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] din,
    input  logic             clr_we,
    input  logic [LINES-1:0] clr_keep,
    output logic [LINES-1:0] cause
);

    logic [LINES-1:0] prev_q;
    logic [LINES-1:0] rise;
    logic [LINES-1:0] kept;

    assign rise = din & ~prev_q;
    assign kept = clr_we ? (cause & clr_keep) : cause;

    // prev_q follows the lines during reset so a high line is not an edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= din;
            cause  <= '0;
        end else begin
            prev_q <= din;
            cause  <= kept | rise;   // a fresh edge beats a clear
        end
    end

endmodule

// File: rtl/gpio_mask_bank.sv
module gpio_mask_bank #(
    parameter int LINES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_edge,
    input  logic             we_level,
    input  logic [LINES-1:0] wdata,
    output logic [LINES-1:0] emask,
    output logic [LINES-1:0] lmask
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            emask <= '0;
            lmask <= '0;
        end else begin
            if (we_edge)  emask <= wdata;
            if (we_level) lmask <= wdata;
        end
    end

endmodule

// File: rtl/gpio_group_or.sv
module gpio_group_or #(
    parameter int LINES   = 32,
    parameter int GROUP_W = 8
) (
    input  logic [LINES-1:0]         din,
    input  logic [LINES-1:0]         lmask,
    input  logic [LINES-1:0]         cause,
    input  logic [LINES-1:0]         emask,
    output logic [LINES/GROUP_W-1:0] irq
);

    localparam int NGROUPS = LINES / GROUP_W;

    logic [LINES-1:0] masked;

    assign masked = (din & lmask) | (cause & emask);

    for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
        assign irq[g] = |masked[g*GROUP_W +: GROUP_W];
    end

endmodule

// File: rtl/gpio_irq_agg.sv
module gpio_irq_agg
    import gpio_irq_pkg::*;
#(
    parameter int LINES   = 32,
    parameter int GROUP_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LINES-1:0]         data_in,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [LINES-1:0]         bus_wdata,
    output logic [LINES-1:0]         bus_rdata,
    output logic [LINES/GROUP_W-1:0] irq_cpu0,
    output logic [LINES/GROUP_W-1:0] irq_cpu1
);

    localparam int NCPU    = 2;
    localparam int NGROUPS = LINES / GROUP_W;

    reg_sel_e         sel;
    logic [LINES-1:0] edge_cause;
    logic [LINES-1:0] emask [NCPU];
    logic [LINES-1:0] lmask [NCPU];
    logic [NGROUPS-1:0] irq_vec [NCPU];

    assign sel = decode_addr(bus_addr);

    gpio_edge_cause #(.LINES(LINES)) u_cause (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (data_in),
        .clr_we   (bus_wr && (sel == SEL_CAUSE)),
        .clr_keep (bus_wdata),
        .cause    (edge_cause)
    );

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        gpio_mask_bank #(.LINES(LINES)) u_masks (
            .clk      (clk),
            .rst_n    (rst_n),
            .we_edge  (bus_wr && (sel == edge_sel(c))),
            .we_level (bus_wr && (sel == level_sel(c))),
            .wdata    (bus_wdata),
            .emask    (emask[c]),
            .lmask    (lmask[c])
        );

        gpio_group_or #(.LINES(LINES), .GROUP_W(GROUP_W)) u_grp (
            .din   (data_in),
            .lmask (lmask[c]),
            .cause (edge_cause),
            .emask (emask[c]),
            .irq   (irq_vec[c])
        );
    end

    assign irq_cpu0 = irq_vec[0];
    assign irq_cpu1 = irq_vec[1];

    always_comb begin
        unique case (sel)
            SEL_CAUSE:  bus_rdata = edge_cause;
            SEL_EMASK0: bus_rdata = emask[0];
            SEL_LMASK0: bus_rdata = lmask[0];
            SEL_EMASK1: bus_rdata = emask[1];
            SEL_LMASK1: bus_rdata = lmask[1];
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_irq_agg_chk.sv
module gpio_irq_agg_chk
    import gpio_irq_pkg::*;
#(
    parameter int LINES   = 32,
    parameter int NGROUPS = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [LINES-1:0]   data_in,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [LINES-1:0]   bus_wdata,
    input logic [LINES-1:0]   cause,
    input logic [LINES-1:0]   emask0,
    input logic [LINES-1:0]   lmask0,
    input logic [LINES-1:0]   emask1,
    input logic [LINES-1:0]   lmask1,
    input logic [NGROUPS-1:0] irq_cpu0,
    input logic [NGROUPS-1:0] irq_cpu1
);

    AST_RISE_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((($past(data_in) & ~$past(data_in, 2)) & ~cause) == '0)); // R2

    AST_CLEAR_BY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_CAUSE) |=>
            ((cause & ~$past(bus_wdata) & ~($past(data_in) & ~$past(data_in, 2))) == '0)); // R3

    AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == OFS_CAUSE) |=> (($past(cause) & ~cause) == '0)); // R2

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (irq_cpu0 == '0 && irq_cpu1 == '0 && cause == '0)); // R9

    AST_CPU0_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_cpu0 != '0) |-> ((emask0 | lmask0) != '0)); // R8

    AST_CPU1_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_cpu1 != '0) |-> ((emask1 | lmask1) != '0)); // R8

endmodule

bind gpio_irq_agg gpio_irq_agg_chk #(.LINES(LINES), .NGROUPS(LINES/GROUP_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .data_in   (data_in),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cause     (edge_cause),
    .emask0    (emask[0]),
    .lmask0    (lmask[0]),
    .emask1    (emask[1]),
    .lmask1    (lmask[1]),
    .irq_cpu0  (irq_cpu0),
    .irq_cpu1  (irq_cpu1)
);

// File: tb/gpio_irq_agg_tb_top.sv
module gpio_irq_agg_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] data_in = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq_cpu0;
    logic [3:0]  irq_cpu1;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    gpio_irq_agg dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_in   (data_in),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_cpu0  (irq_cpu0),
        .irq_cpu1  (irq_cpu1)
    );

    // level-only table: CPU0 level mask 00FF00FF, CPU1 level mask FF00FF00
    localparam int NVEC = 7;
    localparam logic [39:0] VEC [NVEC] = '{
        {32'h0000_0000, 4'b0000, 4'b0000},
        {32'h0000_0001, 4'b0001, 4'b0000},
        {32'h0000_0100, 4'b0000, 4'b0010},
        {32'h8000_0000, 4'b0000, 4'b1000},
        {32'h0080_0000, 4'b0100, 4'b0000},
        {32'hFFFF_FFFF, 4'b0101, 4'b1010},
        {32'h0101_0101, 4'b0101, 4'b1010}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic step(input logic [31:0] d);
        @(negedge clk);
        data_in = d;
        @(negedge clk);
    endtask

    initial begin
        logic [31:0] r;

        // R9: reset with every line high
        data_in = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        check("R9 irq0 in reset", {28'd0, irq_cpu0}, 32'd0);
        check("R9 irq1 in reset", {28'd0, irq_cpu1}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rd(8'h14, r); check("R9 high line at reset release not an edge", r, 32'd0);
        rd(8'h18, r); check("R9 emask0 reset", r, 32'd0);
        rd(8'h34, r); check("R9 lmask1 reset", r, 32'd0);

        step(32'h0);
        wr(8'h1C, 32'h00FF_00FF);
        wr(8'h34, 32'hFF00_FF00);
        rd(8'h1C, r); check("R1 lmask0 readback", r, 32'h00FF_00FF);
        rd(8'h34, r); check("R1 lmask1 readback", r, 32'hFF00_FF00);

        // R5 R7 R8: level table
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            data_in = VEC[i][39:8];
            #1;
            check("R5/R7 irq0 level", {28'd0, irq_cpu0}, {28'd0, VEC[i][7:4]});
            check("R8/R7 irq1 level", {28'd0, irq_cpu1}, {28'd0, VEC[i][3:0]});
        end

        step(32'h0);
        wr(8'h14, 32'h0);
        wr(8'h1C, 32'h0);
        wr(8'h34, 32'h0);
        rd(8'h14, r); check("R3 cleared by zeros", r, 32'h0);

        // R2: edge latching
        wr(8'h18, 32'hFFFF_FFFF);
        step(32'h0000_0008);
        rd(8'h14, r); check("R2 rising sets cause", r, 32'h0000_0008);
        check("R2 irq0 edge", {28'd0, irq_cpu0}, 32'h1);
        check("R8 irq1 unaffected", {28'd0, irq_cpu1}, 32'h0);
        step(32'h0);
        rd(8'h14, r); check("R2 held after fall", r, 32'h0000_0008);
        check("R2 irq0 held", {28'd0, irq_cpu0}, 32'h1);

        // R3: ones keep, zeros clear
        step(32'h0000_1000);
        step(32'h0);
        rd(8'h14, r); check("R2 second edge", r, 32'h0000_1008);
        wr(8'h14, 32'hFFFF_EFFF);
        rd(8'h14, r); check("R3 selective clear", r, 32'h0000_0008);

        // R4: edge and clear collide
        @(negedge clk);
        data_in = 32'h0000_0020;
        bus_wr = 1'b1; bus_addr = 8'h14; bus_wdata = 32'h0;
        @(negedge clk);
        bus_wr = 1'b0;
        rd(8'h14, r); check("R4 edge wins over clear", r, 32'h0000_0020);

        // R6 R8: masks per CPU
        wr(8'h30, 32'h0000_0020);
        wr(8'h18, 32'h0);
        check("R8 irq1 via own emask", {28'd0, irq_cpu1}, 32'h1);
        check("R6 irq0 masked off", {28'd0, irq_cpu0}, 32'h0);
        wr(8'h34, 32'h0100_0000);
        @(negedge clk);
        data_in = 32'h0100_0020;
        #1;
        check("R6 level OR edge", {28'd0, irq_cpu1}, 32'h9);

        // R1: unmapped offset
        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h20, r); check("R1 unmapped reads zero", r, 32'h0);
        rd(8'h30, r); check("R1 emask1 intact", r, 32'h0000_0020);
        rd(8'h1C, r); check("R1 lmask0 intact", r, 32'h0);

        // R9: reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 irq1 after reset", {28'd0, irq_cpu1}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(8'h14, r); check("R9 cause after reset", r, 32'h0);
        rd(8'h30, r); check("R9 emask1 after reset", r, 32'h0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule